// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Alternate Functions

This block models one general-purpose I/O port of a small microcontroller. Each pin has an output latch and a pull-down that is either on, so the pin is driven low, or off, so the pin is released and a weak pull-up takes it high. Writing a 1 to a latch bit releases its pin, and that pin then works as an input. Writing a 0 pulls the pin low.

A two-bit mode input selects how each pull-down is controlled. In plain mode the latch controls it. In address mode a selector drives the pins either from an external address byte or from the latch. In alternate mode the pin goes low when either the latch bit or the peripheral's output bit is 0. The surrounding logic feeds back the resolved pin levels, which pass through a synchronizer before they can be read.

Software has two separate read operations. One returns the latch contents and the other returns the synchronized pin levels. Each read result appears on a registered data output together with a one-cycle valid flag.

Top module: `qb_port`

## Requirements
- R1: After reset every latch bit is 1, `pullDown` is 0 in plain mode, and `rdData` and `rdValid` are 0.
- R2: A cycle with `wrEn` high loads `wrData` into the latch at that clock edge. In plain mode (`mode`=2'b00), `pullDown` then equals the bitwise inverse of the latch, where a 1 means the pin is driven low.
- R3: A cycle with `rdLatchEn` high places the latch contents on `rdData` after the next edge and raises `rdValid` for one cycle. When a write falls in the same cycle, the read returns the value the latch held before that write.
- R4: A cycle with `rdPinEn` high places the synchronized pin levels on `rdData` after the next edge and raises `rdValid`. This value equals `pinIn` provided the pins have been stable for at least three cycles. A pin whose latch bit is 0 reads back 0 when the pins are resolved externally.
- R5: When `rdLatchEn` and `rdPinEn` are both high in one cycle, the latch contents are returned.
- R6: In address mode (`mode`=2'b01), `pullDown` is the inverse of `addrByte` while `addrSel` is 1 and the inverse of the latch while `addrSel` is 0.
- R7: In alternate mode (`mode`=2'b10), `pullDown[i]` is the NAND of latch bit i and `altOut[i]`.
- R8: Mode 2'b11 behaves as plain mode, and `addrSel` and `altOut` have no effect in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 plain, 01 address, 10 alternate, 11 plain |
| addrSel | input | 1 | Address mode selector: 1 drives from the address byte |
| addrByte | input | WIDTH | Address byte for the pins |
| altOut | input | WIDTH | Peripheral output bits gated with the latch |
| wrEn | input | 1 | Latch write strobe |
| wrData | input | WIDTH | Latch write data |
| rdLatchEn | input | 1 | Read-latch request |
| rdPinEn | input | 1 | Read-pin request |
| pinIn | input | WIDTH | Resolved external pin levels |
| pullDown | output | WIDTH | 1 = pin driven low, 0 = released |
| rdData | output | WIDTH | Registered read result |
| rdValid | output | 1 | High for one cycle when `rdData` is new |

## Verification
Two operations can land on the same edge: a latch write and a read-latch access. The bench raises `wrEn` and `rdLatchEn` in one cycle and expects `rdData` to carry the old latch value. It then issues a second read and expects the newly written value. A second collision, both read requests in one cycle, is judged by checking that the latch value rather than the pin value is returned, using pin levels chosen to differ from the latch.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_ADDR  = 2'b01,
    MODE_ALT   = 2'b10,
    MODE_SPARE = 2'b11
  } port_mode_e;

  typedef struct packed {
    logic wrLatch;
    logic rdLatch;
    logic rdPin;
    logic selAddr;
    logic gateAlt;
  } port_strobe_t;
endpackage

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic         addrSel,
  input  logic         wrEn,
  input  logic         rdLatchEn,
  input  logic         rdPinEn,
  output port_strobe_t strobe,
  output logic         rdValid
);
  port_mode_e modeE;

  always_comb begin
    modeE          = port_mode_e'(mode);
    strobe         = '0;
    strobe.wrLatch = wrEn;
    strobe.rdLatch = rdLatchEn;
    strobe.rdPin   = rdPinEn & ~rdLatchEn;
    strobe.selAddr = (modeE == MODE_ADDR) & addrSel;
    strobe.gateAlt = (modeE == MODE_ALT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdLatchEn | rdPinEn;
  end

  // R5: the two read strobes never reach the datapath together
  a_r5_one_read_source: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdLatch && strobe.rdPin));

  // R3/R4: a valid flag always follows a request
  a_r3_valid_follows_request: assert property (@(posedge clk) disable iff (!rstN)
    (rdLatchEn || rdPinEn) |=> rdValid);

  // R8: the spare mode never routes address bits or gates the alternate output
  a_r8_spare_is_plain: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |-> (!strobe.selAddr && !strobe.gateAlt));
endmodule

// File: rtl/qb_port_datapath.sv
module qb_port_datapath
  import qb_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  port_strobe_t       strobe,
  input  logic [WIDTH-1:0]   wrData,
  input  logic [WIDTH-1:0]   addrByte,
  input  logic [WIDTH-1:0]   altOut,
  input  logic [WIDTH-1:0]   pinIn,
  output logic [WIDTH-1:0]   pullDown,
  output logic [WIDTH-1:0]   rdData
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SYNC_STAGES + 1);

  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] driveHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               latchQ <= '1;
    else if (strobe.wrLatch) latchQ <= wrData;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '1;
      else if (s == 0) syncQ[s] <= pinIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    always_comb begin
      if (strobe.selAddr)      driveHigh[b] = addrByte[b];
      else if (strobe.gateAlt) driveHigh[b] = latchQ[b] & altOut[b];
      else                     driveHigh[b] = latchQ[b];
      pullDown[b] = ~driveHigh[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdLatch) rdData <= latchQ;
    else if (strobe.rdPin)   rdData <= syncQ[SYNC_STAGES-1];
  end

  // Checker state: cycles for which pinIn has stayed unchanged
  logic [WIDTH-1:0] prevPin;
  logic [CNT_W-1:0] stableCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin   <= '0;
      stableCnt <= '0;
    end else begin
      prevPin <= pinIn;
      if (pinIn != prevPin)        stableCnt <= '0;
      else if (stableCnt < CNT_MAX) stableCnt <= stableCnt + 1'b1;
    end
  end

  // R1: the latch leaves reset with every pin released
  a_r1_reset_released: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (latchQ == '1));

  // R2: a write lands in the latch on the same edge
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLatch |=> (latchQ == $past(wrData)));

  // R7: in alternate mode no pin is pulled low while both sources are 1
  a_r7_alt_gate: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateAlt |-> ((pullDown & latchQ & altOut) == '0));

  // R6: the address selector releases exactly the pins whose address bit is 1
  a_r6_addr_route: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selAddr |-> ((pullDown ^ addrByte) == '1));

  // R4: a pin read with settled inputs returns the external level
  a_r4_pin_settled: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdPin && stableCnt >= CNT_W'(SYNC_STAGES) && pinIn == prevPin)
      |=> (rdData == $past(pinIn)));
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             addrSel,
  input  logic [WIDTH-1:0] addrByte,
  input  logic [WIDTH-1:0] altOut,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdLatchEn,
  input  logic             rdPinEn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pullDown,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);
  port_strobe_t strobe;

  qb_port_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .addrSel   (addrSel),
    .wrEn      (wrEn),
    .rdLatchEn (rdLatchEn),
    .rdPinEn   (rdPinEn),
    .strobe    (strobe),
    .rdValid   (rdValid)
  );

  qb_port_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .addrByte (addrByte),
    .altOut   (altOut),
    .pinIn    (pinIn),
    .pullDown (pullDown),
    .rdData   (rdData)
  );
endmodule

// File: tb/qb_port_tb.sv
module qb_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         addrSel = 1'b0;
  logic [W-1:0] addrByte = '0;
  logic [W-1:0] altOut = '0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdLatchEn = 1'b0;
  logic         rdPinEn = 1'b0;
  logic [W-1:0] extLevel = '1;
  logic [W-1:0] pinIn;
  logic [W-1:0] pullDown;
  logic [W-1:0] rdData;
  logic         rdValid;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // wired resolution: a pulled-down pin reads low
  assign pinIn = extLevel & ~pullDown;

  qb_port u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .addrSel(addrSel),
    .addrByte(addrByte), .altOut(altOut), .wrEn(wrEn), .wrData(wrData),
    .rdLatchEn(rdLatchEn), .rdPinEn(rdPinEn), .pinIn(pinIn),
    .pullDown(pullDown), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeLatch(input logic [W-1:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readLatch(output logic [W-1:0] v, output logic valid);
    @(negedge clk); rdLatchEn = 1'b1;
    @(negedge clk); rdLatchEn = 1'b0; v = rdData; valid = rdValid;
  endtask

  task automatic readPin(output logic [W-1:0] v);
    @(negedge clk); rdPinEn = 1'b1;
    @(negedge clk); rdPinEn = 1'b0; v = rdData;
  endtask

  task automatic t_reset();
    logic [W-1:0] v; logic ok;
    check("R1 pullDown", pullDown, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    check("R1 rdValid", {7'd0, rdValid}, 8'h00);
    readLatch(v, ok);
    check("R1 latch after reset", v, 8'hFF);
    check("R3 valid flag", {7'd0, ok}, 8'h01);
    @(negedge clk);
    check("R3 valid single cycle", {7'd0, rdValid}, 8'h00);
  endtask

  task automatic t_write();
    logic [W-1:0] v; logic ok;
    writeLatch(8'hA5);
    check("R2 pullDown plain", pullDown, 8'h5A);
    readLatch(v, ok);
    check("R3 read latch", v, 8'hA5);
  endtask

  task automatic t_collide();
    logic [W-1:0] v; logic ok;
    @(negedge clk); wrEn = 1'b1; wrData = 8'h3C; rdLatchEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; rdLatchEn = 1'b0;
    check("R3 write+read returns old", rdData, 8'hA5);
    readLatch(v, ok);
    check("R3 then returns new", v, 8'h3C);
  endtask

  task automatic t_pin();
    logic [W-1:0] v;
    writeLatch(8'hFF);
    extLevel = 8'h96;
    repeat (4) @(negedge clk);
    readPin(v);
    check("R4 released pins read external", v, 8'h96);
    writeLatch(8'h0F);
    extLevel = 8'hFF;
    repeat (4) @(negedge clk);
    readPin(v);
    check("R4 latch-0 pins read low", v, 8'h0F);
  endtask

  task automatic t_priority();
    extLevel = 8'h00;
    repeat (4) @(negedge clk);
    @(negedge clk); rdLatchEn = 1'b1; rdPinEn = 1'b1;
    @(negedge clk); rdLatchEn = 1'b0; rdPinEn = 1'b0;
    check("R5 both reads give latch", rdData, 8'h0F);
    extLevel = 8'hFF;
  endtask

  task automatic t_addr();
    writeLatch(8'h55);
    @(negedge clk); mode = 2'b01; addrSel = 1'b1; addrByte = 8'hC3;
    #1 check("R6 address routed", pullDown, 8'h3C);
    addrSel = 1'b0;
    #1 check("R6 latch routed", pullDown, 8'hAA);
  endtask

  task automatic t_alt();
    writeLatch(8'hF0);
    @(negedge clk); mode = 2'b10; altOut = 8'hAA;
    #1 check("R7 nand gate", pullDown, 8'h5F);
    altOut = 8'hFF;
    #1 check("R7 alt all ones", pullDown, 8'h0F);
  endtask

  task automatic t_spare();
    @(negedge clk); mode = 2'b11; addrSel = 1'b1; addrByte = 8'h00; altOut = 8'h00;
    #1 check("R8 spare mode plain", pullDown, 8'h0F);
    mode = 2'b00;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_collide();
    t_pin();
    t_priority();
    t_addr();
    t_alt();
    t_spare();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule